// File: doc/BRIEF.md
# Microcontroller Program Sequencer with Return Stack

This block produces the fetch address for a small command-processing microcontroller. Each cycle it looks at the instruction that sits at the current fetch address. It receives the six-bit opcode, the 26-bit operand field and the value of the register that the instruction tests. From these it picks the next program counter: one step ahead, a relative branch target, an absolute call target, or an address taken from a hardware return stack. The ALU, the register file and the instruction memory sit outside the block. The register value arrives already read, and the instruction word already fetched.

Two branch families are handled. One compares the tested register with a five-bit immediate. The other tests a single bit of the register that the same five-bit field selects. Calls push the address that follows the call onto an eight-entry return stack. Returns pop it. A return may also mark the end of a context-switch interrupt handler, and it then emits a one-cycle completion pulse. A wait-for-input instruction parks the sequencer with the stall output high until the input stream reports unread data. A call on a full stack, or a return on an empty one, leaves the stack untouched and sets a sticky error flag.

Top module: `prog_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the edge sets `fetch_pc` to 0 and clears `stall`, `irq_done` and `stack_err`.
- R2: An accepted instruction whose opcode is not 0x30 to 0x36 advances `fetch_pc` by one, modulo 2^PC_W. When `instr_valid` is low and the block is not waiting, `fetch_pc` holds.
- R3: Opcode 0x30 branches when `test_val` differs from the zero-extended immediate in `op_fields[20:16]`. Opcode 0x31 branches when they are equal. A branch that is not taken advances by one.
- R4: Opcode 0x32 branches when bit `op_fields[20:16]` of `test_val` is 0. Opcode 0x33 branches when that bit is 1.
- R5: A taken branch loads `fetch_pc` with the branch's own address plus the sign-extended 16-bit offset `op_fields[15:0]`, modulo 2^PC_W.
- R6: Call (0x35) loads `fetch_pc` with `op_fields[PC_W-1:0]` and pushes the call address plus one.
- R7: Return (0x34) loads `fetch_pc` with the most recently pushed address and removes it, in last-in first-out order.
- R8: A return with `op_fields[25]` set raises `irq_done` for exactly the cycle after it is accepted. No other instruction raises it.
- R9: Wait (0x36) accepted with `in_avail` low holds `fetch_pc` and drives `stall` high from the next cycle. Stall persists, ignoring `instr_valid`, until a cycle with `in_avail` high. That cycle advances `fetch_pc` by one and drops `stall`. A wait accepted with `in_avail` high advances at once with no stall.
- R10: The return stack holds DEPTH (8) entries. A call with the stack full still jumps but pushes nothing and sets `stack_err`. A return with the stack empty advances by one and sets `stack_err`.
- R11: `stack_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | The instruction at `fetch_pc` is present this cycle |
| op_code | input | 6 | Opcode of that instruction |
| op_fields | input | 26 | Operand field: offset, immediate or bit index, call target, interrupt-return flag |
| test_val | input | 32 | Value of the register the branch tests |
| in_avail | input | 1 | Input stream holds unread data (write pointer ahead of read pointer) |
| fetch_pc | output | PC_W | Current fetch address |
| stall | output | 1 | Sequencer is waiting for input |
| irq_done | output | 1 | One-cycle pulse: interrupt handler returned |
| stack_err | output | 1 | Sticky return-stack overflow or underflow flag |

## Verification
The hardest state to reach from the ports is a full stack that then has to prove it kept its contents. Filling it needs eight nested calls with no return in between. The proof comes only after a rejected ninth call, by unwinding all eight returns and comparing each target. A directed sequence builds exactly that chain, then drains it into an underflow. A second hard case is a wait that sees new instructions and calls while parked, which must all be ignored. The directed wait sequence injects them, and the random phase mixes waits into long runs of stack and branch traffic, with `in_avail` held low two cycles out of three.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam logic [5:0] OP_BR_NE  = 6'h30;
  localparam logic [5:0] OP_BR_EQ  = 6'h31;
  localparam logic [5:0] OP_BR_BC  = 6'h32;
  localparam logic [5:0] OP_BR_BS  = 6'h33;
  localparam logic [5:0] OP_RETURN = 6'h34;
  localparam logic [5:0] OP_CALL   = 6'h35;
  localparam logic [5:0] OP_WAIT   = 6'h36;

  localparam int OFF_W = 16;
  localparam int SEL_LO = 16;
  localparam int IRQ_BIT = 25;

  typedef enum logic [2:0] {
    ACT_STEP,
    ACT_JUMP,
    ACT_CALL,
    ACT_RET,
    ACT_WAIT
  } act_e;

  function automatic logic is_cond_branch(input logic [5:0] op);
    return (op >= OP_BR_NE) && (op <= OP_BR_BS);
  endfunction

  // R3 / R4 branch condition
  function automatic logic br_taken(input logic [5:0] op, input logic [4:0] sel,
                                    input logic [31:0] v);
    logic hit;
    hit = 1'b0;
    case (op)
      OP_BR_NE: hit = (v != {27'd0, sel});
      OP_BR_EQ: hit = (v == {27'd0, sel});
      OP_BR_BC: hit = ~v[sel];
      OP_BR_BS: hit = v[sel];
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/seq_branch_unit.sv
module seq_branch_unit
  import seq_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic [PC_W-1:0] pc,
  input  logic [5:0]      op,
  input  logic [25:0]     fields,
  input  logic [31:0]     test_val,
  input  logic            in_avail,
  output act_e            act,
  output logic [PC_W-1:0] jump_tgt,
  output logic            ret_irq
);

  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] abs_tgt;
  logic            taken;
  logic            unused_fields;

  assign unused_fields = ^fields;

  // R5: sign-extend (or truncate) the offset to the PC width, wrap on add
  assign off_ext = PC_W'($signed(fields[OFF_W-1:0]));
  assign rel_tgt = pc + off_ext;
  // R6: absolute target
  assign abs_tgt = fields[PC_W-1:0];
  assign taken   = br_taken(op, fields[SEL_LO+4:SEL_LO], test_val);
  assign ret_irq = (op == OP_RETURN) && fields[IRQ_BIT];

  always_comb begin
    act      = ACT_STEP;
    jump_tgt = rel_tgt;
    if (is_cond_branch(op)) begin
      act = taken ? ACT_JUMP : ACT_STEP;
    end else begin
      case (op)
        OP_CALL: begin
          act      = ACT_CALL;
          jump_tgt = abs_tgt;
        end
        OP_RETURN: act = ACT_RET;
        OP_WAIT:   act = in_avail ? ACT_STEP : ACT_WAIT;
        default:   act = ACT_STEP;
      endcase
    end
  end

endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
  parameter int PC_W  = 12,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_req,
  input  logic            pop_req,
  input  logic [PC_W-1:0] push_data,
  output logic [PC_W-1:0] top,
  output logic            empty,
  output logic            full,
  output logic            err
);

  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [SP_W-1:0] sp;
  logic [PC_W-1:0] slots [DEPTH];
  logic            do_push;
  logic            do_pop;
  logic            bad_op;

  assign empty   = (sp == '0);
  assign full    = (sp == SP_W'(DEPTH));
  assign do_push = push_req && !full;
  assign do_pop  = pop_req && !empty;
  assign bad_op  = (push_req && full) || (pop_req && empty);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [PC_W-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (do_push && sp == SP_W'(i)) ent_q <= push_data;
    end
    assign slots[i] = ent_q;
  end

  assign top = empty ? '0 : slots[IDX_W'(sp - 1'b1)];

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= '0;
      err <= 1'b0;
    end else begin
      if (do_push)      sp <= sp + 1'b1;
      else if (do_pop)  sp <= sp - 1'b1;
      if (bad_op)       err <= 1'b1;
    end
  end

  p_sp_bound_r10: assert property (@(posedge clk) disable iff (rst)
    sp <= SP_W'(DEPTH));

  p_full_keeps_sp_r10: assert property (@(posedge clk) disable iff (rst)
    (push_req && full) |=> $stable(sp));

  p_empty_keeps_sp_r10: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty) |=> $stable(sp));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

endmodule

// File: rtl/seq_wait_ctl.sv
module seq_wait_ctl (
  input  logic clk,
  input  logic rst,
  input  logic park,
  input  logic in_avail,
  output logic waiting,
  output logic resume
);

  assign resume = waiting && in_avail;

  always_ff @(posedge clk) begin
    if (rst)          waiting <= 1'b0;
    else if (resume)  waiting <= 1'b0;
    else if (park)    waiting <= 1'b1;
  end

  p_resume_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (waiting && in_avail) |=> !waiting);

  p_park_sets_r9: assert property (@(posedge clk) disable iff (rst)
    (!waiting && park) |=> waiting);

endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
  import seq_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  input  logic [5:0]      op_code,
  input  logic [25:0]     op_fields,
  input  logic [31:0]     test_val,
  input  logic            in_avail,
  output logic [PC_W-1:0] fetch_pc,
  output logic            stall,
  output logic            irq_done,
  output logic            stack_err
);

  act_e            act;
  logic [PC_W-1:0] jump_tgt;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_nxt;
  logic [PC_W-1:0] ret_addr;
  logic            ret_irq;
  logic            waiting;
  logic            resume;
  logic            exec;
  logic            exec_call;
  logic            exec_ret;
  logic            exec_park;
  logic            stk_empty;
  logic            stk_full;

  assign exec      = instr_valid && !waiting;
  assign exec_call = exec && (act == ACT_CALL);
  assign exec_ret  = exec && (act == ACT_RET);
  assign exec_park = exec && (act == ACT_WAIT);
  assign pc_inc    = fetch_pc + 1'b1;

  seq_branch_unit #(.PC_W(PC_W)) u_branch (
    .pc       (fetch_pc),
    .op       (op_code),
    .fields   (op_fields),
    .test_val (test_val),
    .in_avail (in_avail),
    .act      (act),
    .jump_tgt (jump_tgt),
    .ret_irq  (ret_irq)
  );

  seq_ret_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push_req  (exec_call),
    .pop_req   (exec_ret),
    .push_data (pc_inc),
    .top       (ret_addr),
    .empty     (stk_empty),
    .full      (stk_full),
    .err       (stack_err)
  );

  seq_wait_ctl u_wait (
    .clk      (clk),
    .rst      (rst),
    .park     (exec_park),
    .in_avail (in_avail),
    .waiting  (waiting),
    .resume   (resume)
  );

  always_comb begin
    pc_nxt = fetch_pc;
    if (waiting) begin
      if (resume) pc_nxt = pc_inc;
    end else if (instr_valid) begin
      case (act)
        ACT_JUMP: pc_nxt = jump_tgt;
        ACT_CALL: pc_nxt = jump_tgt;
        ACT_RET:  pc_nxt = stk_empty ? pc_inc : ret_addr;
        ACT_WAIT: pc_nxt = fetch_pc;
        default:  pc_nxt = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc <= '0;
      irq_done <= 1'b0;
    end else begin
      fetch_pc <= pc_nxt;
      irq_done <= exec_ret && ret_irq;
    end
  end

  assign stall = waiting;

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!instr_valid && !stall) |=> fetch_pc == $past(fetch_pc));

  p_call_target_r6: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !stall && op_code == OP_CALL)
      |=> fetch_pc == $past(op_fields[PC_W-1:0]));

  p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> $past(instr_valid && !stall && op_code == OP_RETURN && op_fields[25]));

  p_wait_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (stall && !in_avail) |=> stall && $stable(fetch_pc));

  p_no_stall_no_err_r1: assert property (@(posedge clk)
    rst |=> !stall && !irq_done && !stack_err && fetch_pc == '0);

endmodule

// File: tb/prog_sequencer_tb.sv
module prog_sequencer_tb;
  localparam int CLK_NS = 10;
  localparam int PC_W   = 12;
  localparam int DEPTH  = 8;
  localparam int MASK   = (1 << PC_W) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            instr_valid = 1'b0;
  logic [5:0]      op_code = '0;
  logic [25:0]     op_fields = '0;
  logic [31:0]     test_val = '0;
  logic            in_avail = 1'b0;
  logic [PC_W-1:0] fetch_pc;
  logic            stall;
  logic            irq_done;
  logic            stack_err;

  int n_run  = 0;
  int n_fail = 0;

  int m_pc;
  int m_sp;
  int m_stk [DEPTH];
  bit m_err, m_wait, m_irq;

  always #(CLK_NS/2) clk = ~clk;

  prog_sequencer #(.PC_W(PC_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .op_code(op_code),
    .op_fields(op_fields), .test_val(test_val), .in_avail(in_avail),
    .fetch_pc(fetch_pc), .stall(stall), .irq_done(irq_done), .stack_err(stack_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_taken(input int op, input int sel, input logic [31:0] v);
    case (op)
      'h30: return v != 32'(sel);
      'h31: return v == 32'(sel);
      'h32: return v[sel] == 1'b0;
      'h33: return v[sel] == 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int sext16(input logic [15:0] x);
    return int'($signed(x));
  endfunction

  task automatic model(input int op, input logic [25:0] f, input logic [31:0] tv,
                       input bit v, input bit av);
    m_irq = 0;
    if (m_wait) begin
      if (av) begin m_wait = 0; m_pc = (m_pc + 1) & MASK; end
    end else if (v) begin
      if (op >= 'h30 && op <= 'h33) begin
        if (exp_taken(op, int'(f[20:16]), tv)) m_pc = (m_pc + sext16(f[15:0])) & MASK;
        else m_pc = (m_pc + 1) & MASK;
      end else if (op == 'h34) begin
        m_irq = f[25];
        if (m_sp == 0) begin m_err = 1; m_pc = (m_pc + 1) & MASK; end
        else begin m_sp--; m_pc = m_stk[m_sp]; end
      end else if (op == 'h35) begin
        if (m_sp == DEPTH) m_err = 1;
        else begin m_stk[m_sp] = (m_pc + 1) & MASK; m_sp++; end
        m_pc = int'(f) & MASK;
      end else if (op == 'h36) begin
        if (av) m_pc = (m_pc + 1) & MASK;
        else m_wait = 1;
      end else begin
        m_pc = (m_pc + 1) & MASK;
      end
    end
  endtask

  task automatic step(input int op, input logic [25:0] f, input logic [31:0] tv,
                      input bit v, input bit av, input string tag);
    @(negedge clk);
    op_code = 6'(op); op_fields = f; test_val = tv; instr_valid = v; in_avail = av;
    model(op, f, tv, v, av);
    @(posedge clk);
    #1;
    chk({tag, " pc"}, int'(fetch_pc), m_pc);
    chk("R9 stall", int'(stall), int'(m_wait));
    chk("R8 irq_done", int'(irq_done), int'(m_irq));
    chk("R10 stack_err", int'(stack_err), int'(m_err));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; instr_valid = 0; in_avail = 0;
    @(posedge clk); @(posedge clk); #1;
    m_pc = 0; m_sp = 0; m_err = 0; m_wait = 0; m_irq = 0;
    chk("R1 reset pc", int'(fetch_pc), 0);
    chk("R1 reset stall", int'(stall), 0);
    chk("R1 reset irq", int'(irq_done), 0);
    chk("R1 reset err", int'(stack_err), 0);
    @(negedge clk); rst = 0;
  endtask

  function automatic logic [25:0] brf(input int sel, input int off);
    return {5'd0, 5'(sel), 16'(off)};
  endfunction

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    do_reset();
    // R2 plain step and idle hold
    step('h02, 26'd0, 0, 1, 0, "R2 step");
    step('h02, 26'd0, 0, 0, 0, "R2 idle hold");
    step('h3a, 26'd0, 0, 1, 0, "R2 high unused opcode");
    // R3 compare branches
    step('h30, brf(5, 10), 32'd5, 1, 0, "R3 ne not taken");
    step('h30, brf(5, 10), 32'd4, 1, 0, "R3 ne taken");
    step('h31, brf(9, -3), 32'd9, 1, 0, "R3 eq taken back");
    step('h31, brf(9, 100), 32'h109, 1, 0, "R3 eq not taken");
    // R5 wrap below zero
    step('h31, brf(0, -100), 32'd0, 1, 0, "R5 wrap negative");
    step('h30, brf(1, 32767), 32'd0, 1, 0, "R5 large offset");
    // R4 bit tests
    step('h33, brf(7, 4), 32'h80, 1, 0, "R4 bit set taken");
    step('h32, brf(7, 4), 32'h80, 1, 0, "R4 bit clear not taken");
    step('h32, brf(31, 6), 32'h7fffffff, 1, 0, "R4 bit31 clear taken");
    step('h33, brf(0, 6), 32'hfffffffe, 1, 0, "R4 bit0 set not taken");
    // R6 / R7 nested call and return
    step('h35, 26'h100, 0, 1, 0, "R6 call");
    step('h35, 26'h3ff_f200, 0, 1, 0, "R6 call truncated");
    step('h02, 26'd0, 0, 1, 0, "R2 step in callee");
    step('h34, 26'd0, 0, 1, 0, "R7 inner return");
    step('h34, 26'd0, 0, 1, 0, "R7 outer return");
    // R8 interrupt return
    step('h35, 26'h040, 0, 1, 0, "R6 call");
    step('h34, 26'h200_0000, 0, 1, 0, "R8 return irq");
    step('h02, 26'd0, 0, 1, 0, "R8 pulse ends");
    // R9 wait
    step('h36, 26'd0, 0, 1, 0, "R9 park");
    step('h35, 26'h123, 0, 1, 0, "R9 ignored while parked");
    step('h02, 26'd0, 0, 0, 0, "R9 still parked");
    step('h35, 26'h123, 0, 1, 1, "R9 resume");
    step('h36, 26'd0, 0, 1, 1, "R9 data ready no stall");
    // R10 underflow, R11 sticky
    do_reset();
    step('h34, 26'd0, 0, 1, 0, "R10 underflow");
    step('h02, 26'd0, 0, 1, 0, "R11 err sticky");
    // R10 overflow then full unwind
    do_reset();
    for (int i = 0; i < DEPTH + 1; i++) step('h35, 26'(16 * (i + 1)), 0, 1, 0, "R10 call chain");
    for (int i = 0; i < DEPTH; i++) step('h34, 26'd0, 0, 1, 0, "R10 unwind intact");
    step('h34, 26'd0, 0, 1, 0, "R10 underflow after unwind");
    do_reset();
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      int op;
      logic [25:0] f;
      logic [31:0] tv;
      r = $urandom_range(0, 9);
      if (r <= 6) op = 'h30 + r;
      else if (r <= 8) op = $urandom_range(0, 'h2f);
      else op = $urandom_range('h37, 'h3f);
      f = 26'($urandom);
      tv = ($urandom_range(0, 1) == 1) ? 32'(f[20:16]) : $urandom;
      step(op, f, tv, $urandom_range(0, 9) != 0, $urandom_range(0, 2) == 0,
           "R3 R4 R5 R6 R7 random");
      if (n % 1000 == 999) do_reset();
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule